// File: doc/BRIEF.md
# Deterministic-Latency Comma Aligner

This block finds the 10-bit word boundary of a receive lane without shifting any data itself. It watches the parallel words from a deserializer for the K28.5 comma. While the comma is not at the start of a word, it sends a one-cycle slip command back to the deserializer, which moves its boundary by one bit. The aligner then waits a fixed number of clocks for the new boundary to show up before it looks again. The data path through the block is always a single register stage, so the receive latency is the same every time the lane locks.

A search starts from an alignment request. In deterministic mode the request acts on its rising edge only, and the search then runs on its own. In manual mode with a 10-bit deserializer width, the request is a level: the search runs only while it is held high. Lock is declared after a run of commas at the word start. Lock is dropped after repeated commas at a shifted position, and the search then starts again. Slipping is forbidden while locked.

Top module: `slip_word_aligner`

## Requirements
- R1: After reset, `sync_ok` and `slip_pulse` are 0 and stay 0 until an alignment request starts a search.
- R2: Either disparity form of K28.5 counts as the comma: `rx_word` equal to 10'b0011111010 or to 10'b1100000101. Bit 9 is the first serial bit.
- R3: Each slip command is a `slip_pulse` high for exactly one clock. During a continuous search, consecutive pulses are SETTLE_CYC+1 clocks apart (5 by default).
- R4: With `mode_manual` = 0, only a rising edge of `align_req` starts a search. A request already high when reset is released does nothing. Lowering the request after the edge does not stop the search.
- R5: With `mode_manual` = 1 and PMA_W = 10, a search runs while `align_req` is high. Lowering the request stops further slip pulses and leaves the block unsynced.
- R6: With no comma in the stream, slipping continues past a full word of slips (more than 10) and `sync_ok` stays 0.
- R7: `sync_ok` rises on the clock edge that samples the third aligned comma in a row with no slip between them. With a steady comma stream, that is the seventh clock after the final slip pulse.
- R8: In lock, a word whose two-word window holds a comma at a nonzero bit offset is a mismatch. An aligned comma clears the mismatch count. The fourth mismatch in a row clears `sync_ok`, and the search (with slipping) resumes.
- R9: `slip_pulse` is 0 in every cycle in which `sync_ok` is 1.
- R10: `word_out` equals the `rx_word` sampled at the previous clock edge, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_manual | input | 1 | 0 = deterministic (edge request), 1 = manual |
| align_req | input | 1 | Alignment request |
| rx_word | input | WORD_W | Parallel word from the deserializer, bit 9 first on the line |
| slip_pulse | output | 1 | One-clock command to move the deserializer boundary by one bit |
| sync_ok | output | 1 | Word boundary locked |
| word_out | output | WORD_W | Registered word towards the 8B/10B decoder |

## Verification
`word_out` is due one clock after each input word. A scoreboard queue pops one expected word per falling edge, once two words have been queued. A slip pulse is visible for a single cycle. The bench's deserializer model applies it just after the edge that raised it, and the bench requires the next pulse five edges later. Lock is due on the seventh edge after the last slip, so the bench samples `sync_ok` low at the sixth falling edge and high at the seventh. After a one-bit boundary shift is injected, the first shifted word is sampled on the second edge. The fourth mismatch then falls on the fifth edge, so `sync_ok` is checked high at the fourth falling edge and low at the fifth.

// File: rtl/swa_pkg.sv
package swa_pkg;
   localparam int COMMA_W = 10;
   localparam logic [COMMA_W-1:0] K285_NEG = 10'b0011111010;
   localparam logic [COMMA_W-1:0] K285_POS = 10'b1100000101;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_SETTLE,
      ST_CONFIRM,
      ST_LOCKED
   } align_st_e;

   function automatic logic is_comma(input logic [COMMA_W-1:0] w);
      return (w == K285_NEG) || (w == K285_POS);
   endfunction
endpackage

// File: rtl/swa_comma_scan.sv
module swa_comma_scan #(
   parameter int WORD_W = 10
) (
   input  logic [WORD_W-1:0] cur_word,
   input  logic [WORD_W-1:0] prev_word,
   output logic              aligned_hit,
   output logic              shifted_hit
);
   localparam int WIN_W = 2 * WORD_W;

   logic [WIN_W-1:0]  win;
   logic [WORD_W-2:0] off_hit;

   assign win = {prev_word, cur_word};

   // one detector per nonzero bit offset inside the two-word window
   for (genvar j = 1; j < WORD_W; j++) begin : g_off
      assign off_hit[j-1] = swa_pkg::is_comma(win[WIN_W-1-j -: WORD_W]);
   end

   assign aligned_hit = swa_pkg::is_comma(cur_word);
   assign shifted_hit = |off_hit;
endmodule

// File: rtl/swa_req_gate.sv
module swa_req_gate #(
   parameter int PMA_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_manual,
   input  logic align_req,
   output logic start,
   output logic keep
);
   logic req_q;
   logic req_rise;

   // reset high: a request held through reset is not an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b1;
      else        req_q <= align_req;
   end

   assign req_rise = align_req & ~req_q;

   if (PMA_W == 10) begin : g_level_manual
      assign start = mode_manual ? align_req : req_rise;
      assign keep  = mode_manual ? align_req : 1'b1;
   end else begin : g_edge_only
      logic mode_unused;
      assign mode_unused = mode_manual;
      assign start = req_rise;
      assign keep  = 1'b1;
   end
endmodule

// File: rtl/swa_sync_fsm.sv
module swa_sync_fsm #(
   parameter int SETTLE_CYC  = 4,
   parameter int SYNC_HITS   = 3,
   parameter int LOSS_MISSES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic keep,
   input  logic aligned_hit,
   input  logic shifted_hit,
   output logic slip_pulse,
   output logic sync_ok
);
   import swa_pkg::*;

   localparam int WW = $clog2(SETTLE_CYC + 1);
   localparam int HW = $clog2(SYNC_HITS + 1);
   localparam int MW = $clog2(LOSS_MISSES + 1);
   localparam logic [WW-1:0] WAIT_LAST = WW'(SETTLE_CYC - 1);
   localparam logic [HW-1:0] HIT_LAST  = HW'(SYNC_HITS - 1);
   localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_MISSES - 1);

   align_st_e      st;
   logic [WW-1:0]  wait_cnt;
   logic [HW-1:0]  hit_cnt;
   logic [MW-1:0]  miss_cnt;
   logic           slip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         wait_cnt <= '0;
         hit_cnt  <= '0;
         miss_cnt <= '0;
         slip_q   <= 1'b0;
      end else begin
         slip_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) st <= ST_HUNT;
            end
            ST_HUNT: begin
               if (!keep) begin
                  st <= ST_IDLE;
               end else if (aligned_hit) begin
                  st      <= ST_CONFIRM;
                  hit_cnt <= HW'(1);
               end else begin
                  slip_q   <= 1'b1;
                  wait_cnt <= '0;
                  st       <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (!keep)                  st <= ST_IDLE;
               else if (wait_cnt == WAIT_LAST) st <= ST_HUNT;
               else                        wait_cnt <= wait_cnt + 1'b1;
            end
            ST_CONFIRM: begin
               if (!keep) begin
                  st <= ST_IDLE;
               end else if (aligned_hit) begin
                  if (hit_cnt == HIT_LAST) begin
                     st       <= ST_LOCKED;
                     miss_cnt <= '0;
                  end else begin
                     hit_cnt <= hit_cnt + 1'b1;
                  end
               end else if (shifted_hit) begin
                  st <= ST_HUNT;
               end
            end
            ST_LOCKED: begin
               if (aligned_hit) begin
                  miss_cnt <= '0;
               end else if (shifted_hit) begin
                  if (miss_cnt == MISS_LAST) begin
                     st       <= ST_HUNT;
                     miss_cnt <= '0;
                  end else begin
                     miss_cnt <= miss_cnt + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign slip_pulse = slip_q;
   assign sync_ok    = (st == ST_LOCKED);
endmodule

// File: rtl/slip_word_aligner.sv
module slip_word_aligner #(
   parameter int WORD_W      = 10,
   parameter int PMA_W       = 10,
   parameter int SETTLE_CYC  = 4,
   parameter int SYNC_HITS   = 3,
   parameter int LOSS_MISSES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_manual,
   input  logic              align_req,
   input  logic [WORD_W-1:0] rx_word,
   output logic              slip_pulse,
   output logic              sync_ok,
   output logic [WORD_W-1:0] word_out
);
   if (WORD_W != swa_pkg::COMMA_W) begin : g_bad_width
      $error("WORD_W must equal the comma width");
   end
   if (PMA_W != 10 && PMA_W != 20) begin : g_bad_pma
      $error("PMA_W must be 10 or 20");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end
   if (SYNC_HITS < 2) begin : g_bad_hits
      $error("SYNC_HITS must be at least 2");
   end
   if (LOSS_MISSES < 1) begin : g_bad_loss
      $error("LOSS_MISSES must be at least 1");
   end

   logic [WORD_W-1:0] word_q;
   logic              aligned_hit;
   logic              shifted_hit;
   logic              start;
   logic              keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= rx_word;
   end

   assign word_out = word_q;

   swa_comma_scan #(.WORD_W(WORD_W)) u_scan (
      .cur_word    (rx_word),
      .prev_word   (word_q),
      .aligned_hit (aligned_hit),
      .shifted_hit (shifted_hit)
   );

   swa_req_gate #(.PMA_W(PMA_W)) u_req (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_manual (mode_manual),
      .align_req   (align_req),
      .start       (start),
      .keep        (keep)
   );

   swa_sync_fsm #(
      .SETTLE_CYC  (SETTLE_CYC),
      .SYNC_HITS   (SYNC_HITS),
      .LOSS_MISSES (LOSS_MISSES)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .keep        (keep),
      .aligned_hit (aligned_hit),
      .shifted_hit (shifted_hit),
      .slip_pulse  (slip_pulse),
      .sync_ok     (sync_ok)
   );
endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
   parameter int WORD_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] rx_word,
   input logic [WORD_W-1:0] word_out,
   input logic              slip_pulse,
   input logic              sync_ok
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R3
   slip_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slip_pulse |=> !slip_pulse);

   // R9
   no_slip_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_ok |-> !slip_pulse);

   // R7
   lock_on_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(sync_ok)) |-> swa_pkg::is_comma($past(rx_word)));

   // R10
   fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (word_out == $past(rx_word)));
endmodule

bind slip_word_aligner swa_checker #(.WORD_W(WORD_W)) u_swa_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_word    (rx_word),
   .word_out   (word_out),
   .slip_pulse (slip_pulse),
   .sync_ok    (sync_ok)
);

// File: tb/slip_word_aligner_bench.sv
module slip_word_aligner_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;
   localparam logic [9:0] KNEG  = 10'b0011111010;
   localparam logic [9:0] KPOS  = 10'b1100000101;
   localparam logic [9:0] NOISE = 10'h155;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_manual = 1'b0;
   logic       align_req = 1'b0;
   logic [9:0] rx_word = NOISE;
   logic       slip_pulse;
   logic       sync_ok;
   logic [9:0] word_out;

   int n_checks = 0;
   int n_err = 0;
   int offset = 0;
   int src = 0;
   bit bump = 1'b0;
   logic [9:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   slip_word_aligner u_slip_word_aligner (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_manual (mode_manual),
      .align_req   (align_req),
      .rx_word     (rx_word),
      .slip_pulse  (slip_pulse),
      .sync_ok     (sync_ok),
      .word_out    (word_out)
   );

   function automatic logic [9:0] rot(input logic [9:0] p, input int k);
      logic [19:0] t;
      t = {p, p} << k;
      return t[19:10];
   endfunction

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // deserializer model: slips one bit just after the edge raising slip_pulse
   always @(posedge clk) begin
      #1;
      if (slip_pulse) offset = (offset + 1) % 10;
      if (bump) begin
         offset = (offset + 1) % 10;
         bump = 1'b0;
      end
      rx_word = (src == 2) ? NOISE : rot((src == 1) ? KPOS : KNEG, offset);
      if (rst_n) exp_q.push_back(rx_word);
   end

   // scoreboard monitor for the one-clock word path
   always @(negedge clk) begin
      logic [9:0] e;
      if (!rst_n) exp_q.delete();
      else if (exp_q.size() >= 2) begin
         e = exp_q.pop_front();
         check(word_out == e, "R10 word_out delay", word_out, e);
      end
   end

   task automatic do_reset(input bit req_level, input bit manual, input int s, input int off);
      @(negedge clk);
      rst_n = 1'b0;
      align_req = req_level;
      mode_manual = manual;
      src = s;
      offset = off;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // counts exp_slips pulses, checks spacing, then lock timing
   task automatic search_and_lock(input int exp_slips, input string rq);
      int n = 0;
      int last = -1;
      int gap_bad = 0;
      int extra = 0;
      for (int cyc = 0; cyc < 400 && n < exp_slips; cyc++) begin
         @(negedge clk);
         if (slip_pulse) begin
            if (last >= 0 && cyc - last != SETTLE + 1) gap_bad++;
            last = cyc;
            n++;
         end
      end
      check(n == exp_slips, {rq, " slip count"}, n, exp_slips);
      check(gap_bad == 0, "R3 slip spacing", gap_bad, 0);
      repeat (6) begin
         @(negedge clk);
         if (slip_pulse) extra++;
      end
      check(sync_ok == 1'b0, "R7 no lock before third comma", sync_ok, 0);
      @(negedge clk);
      check(sync_ok == 1'b1, "R7 lock on third comma", sync_ok, 1);
      check(extra == 0, "R3 no slip while confirming", extra, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin : main
      int n;

      // R1: idle after reset, no request
      do_reset(1'b0, 1'b0, 0, 3);
      n = 0;
      repeat (20) begin
         @(negedge clk);
         if (slip_pulse) n++;
      end
      check(n == 0, "R1 no slip without request", n, 0);
      check(sync_ok == 1'b0, "R1 unsynced after reset", sync_ok, 0);

      // R4: request held through reset is ignored
      do_reset(1'b1, 1'b0, 0, 3);
      n = 0;
      repeat (30) begin
         @(negedge clk);
         if (slip_pulse) n++;
      end
      check(n == 0, "R4 held request is not an edge", n, 0);
      check(sync_ok == 1'b0, "R4 still unsynced", sync_ok, 0);
      align_req = 1'b0;
      repeat (2) @(negedge clk);
      align_req = 1'b1;
      @(negedge clk);
      align_req = 1'b0;
      // R4 search goes on with request low; R2 negative-disparity comma
      search_and_lock(7, "R4 R2");

      // R9: no slips in lock
      n = 0;
      repeat (20) begin
         @(negedge clk);
         if (slip_pulse) n++;
      end
      check(n == 0, "R9 no slip in lock", n, 0);
      check(sync_ok == 1'b1, "R9 lock held", sync_ok, 1);

      // R8: one-bit boundary shift, fourth mismatch drops lock
      bump = 1'b1;
      repeat (4) @(negedge clk);
      check(sync_ok == 1'b1, "R8 lock after three mismatches", sync_ok, 1);
      @(negedge clk);
      check(sync_ok == 1'b0, "R8 lock lost on fourth mismatch", sync_ok, 0);
      search_and_lock(9, "R8 resumed search");

      // R2: positive-disparity comma
      do_reset(1'b0, 1'b0, 1, 5);
      @(negedge clk);
      align_req = 1'b1;
      @(negedge clk);
      search_and_lock(5, "R2 positive form");

      // R6: no comma, slipping wraps past a word
      do_reset(1'b0, 1'b0, 2, 0);
      @(negedge clk);
      align_req = 1'b1;
      n = 0;
      repeat (100) begin
         @(negedge clk);
         if (slip_pulse) n++;
      end
      check(n > 10, "R6 slips beyond one word", n, 11);
      check(sync_ok == 1'b0, "R6 no lock without comma", sync_ok, 0);
      src = 0;
      n = 0;
      for (int c = 0; c < 300 && !sync_ok; c++) @(negedge clk);
      check(sync_ok == 1'b1, "R6 lock once comma appears", sync_ok, 1);

      // R5: manual level request
      do_reset(1'b0, 1'b1, 0, 4);
      @(negedge clk);
      align_req = 1'b1;
      n = 0;
      for (int c = 0; c < 100 && n < 2; c++) begin
         @(negedge clk);
         if (slip_pulse) n++;
      end
      align_req = 1'b0;
      n = 0;
      repeat (40) begin
         @(negedge clk);
         if (slip_pulse) n++;
      end
      check(n == 0, "R5 slipping stops when request low", n, 0);
      check(sync_ok == 1'b0, "R5 unsynced after abort", sync_ok, 0);
      align_req = 1'b1;
      search_and_lock(4, "R5 level search");

      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule